// File: doc/BRIEF.md
# SMBus Register Slave

This block is a serial-bus slave that a host controller uses to read and program a small bank of 8-bit control registers. It samples SCL and SDA with the system clock and pulls SDA low through an open-drain enable when it acknowledges or returns a zero bit. Every register appears in parallel on a flat output bus, so neighbouring logic can use the settings directly.

Bit 7 of the command byte picks the access type. When it is set, the access touches the single register whose offset is in bits 6:0. When it is clear, the access is a block transfer that always starts at register 0 and moves upward one register per byte. A block write carries a byte-count byte ahead of its data, unless the count-skip bit in the control register is set. A block read returns the register count first and then the register contents. Register 2 holds the strap pins in its low bits, and register 3 holds an ID byte. Software cannot change either of these.

Top module: `smb_regbank`

## Requirements
- R1: After reset, registers 0 and 1 read FFh, registers 4 and up read 00h, the writable bits of register 2 are 0, and SDA is not driven.
- R2: The slave answers only the 7-bit address 69h, which is byte D2h for a write and D3h for a read. For any other address it gives no ACK, and the bytes that follow until the next start have no effect.
- R3: The slave pulls SDA low during the ninth clock of every address, command, count and write-data byte it accepts. It changes its SDA drive only while SCL is low.
- R4: A command byte with bit 7 = 1 starts a byte write at the offset in bits 6:0. The data byte that follows is stored at that offset.
- R5: A byte read (write address, command with bit 7 = 1, repeated start, read address) returns the register at the offset, most significant bit first. After the master's NACK the slave releases SDA.
- R6: A command byte with bit 7 = 0 starts a block write. The next byte is a count and is not stored. The data bytes then go to registers 0, 1, 2 and upward in that order. A stop after any complete byte leaves the later registers unchanged.
- R7: While register 2 bit 7 (count-skip) is 1, a block write has no count byte, and the first data byte goes to register 0.
- R8: A block read returns the register count (NREG) first, then register 0 and upward. It continues for as long as the master sends ACK.
- R9: Register 2 bits 2:0 always show the strap inputs, and register 3 always shows the ID input. Writes to these bits are ignored.
- R10: Offsets at or beyond NREG read as 00h. Writes to them are acknowledged but change nothing.
- R11: Register k appears on `regs_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; loads the defaults |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | NSTRAP | Latched strap levels, read-only in register 2 |
| id_i | input | 8 | Identification byte, read-only in register 3 |
| regs_o | output | 8*NREG | All registers, register k at bits 8k+7:8k |

## Verification
The hardest situations to reach from the ports depend on earlier bus history rather than on the byte in flight. One is a block write cut off by a stop after only part of its data. Another is a block write issued after the count-skip bit was turned on by an earlier byte write, so the first data byte must not be taken as a count. The stimulus first sets register 2 through a byte write, then issues a count-free block write and checks registers 0 and 1 at the ports. A second block write with a count of five is stopped after two data bytes. A final block read runs past the last register, so the zero returned for missing offsets and the count byte in front of the data are both observed in one transfer.

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int          NREG     = 6,
  parameter int          NEN      = 2,
  parameter int          NSTRAP   = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [NSTRAP-1:0]    strap_i,
  input  logic [7:0]           id_i,
  output logic [8*NREG-1:0]    regs_o
);
  localparam int         CTL  = 2;
  localparam int         IDR  = 3;
  localparam logic [7:0] NCNT = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] bitc;
  logic [7:0] sh;
  logic [6:0] ptr;
  logic       oe, rw, blk;
  logic [NREG-1:0][7:0] vb;
  logic [7:0] rd_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire sda_s    = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire [6:0] ptr_inc = (ptr == 7'h7f) ? ptr : ptr + 7'd1;
  wire wr_go   = (st == S_WR) && scl_fall && (bitc == 4'd8) && !start_c && !stop_c;
  wire skip    = vb[CTL][7];

  always_comb begin
    rd_val = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (ptr == 7'(k)) rd_val = vb[k];
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == IDR) begin : g_id
      assign vb[k] = id_i;
    end else if (k == CTL) begin : g_ctl
      logic [7:NSTRAP] hi;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          hi <= '0;
        else if (wr_go && ptr == 7'(k))      hi <= sh[7:NSTRAP];
      assign vb[k] = {hi, strap_i};
    end else begin : g_rw
      localparam logic [7:0] DEF = (k < NEN) ? 8'hFF : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          q <= DEF;
        else if (wr_go && ptr == 7'(k))      q <= sh;
      assign vb[k] = q;
    end
  end

  assign regs_o = vb;
  assign sda_oe = oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      bitc <= '0;
      sh   <= '0;
      ptr  <= '0;
      oe   <= 1'b0;
      rw   <= 1'b0;
      blk  <= 1'b0;
    end else if (start_c) begin
      st   <= S_ADDR;
      bitc <= '0;
      oe   <= 1'b0;
    end else if (stop_c) begin
      st   <= S_IDLE;
      bitc <= '0;
      oe   <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (st == S_RD && bitc == 4'd8 && sda_s) begin
          st   <= S_IDLE;
          bitc <= '0;
        end else begin
          bitc <= bitc + 4'd1;
          if (st != S_RD && bitc < 4'd8) sh <= {sh[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (bitc == 4'd8) begin
          case (st)
            S_ADDR:
              if (sh[7:1] == DEV_ADDR) begin
                oe <= 1'b1;
                rw <= sh[0];
              end else begin
                st   <= S_IDLE;
                bitc <= '0;
              end
            S_CMD: begin
              oe  <= 1'b1;
              blk <= ~sh[7];
              ptr <= sh[7] ? sh[6:0] : 7'd0;
            end
            S_CNT: oe <= 1'b1;
            S_WR: begin
              oe  <= 1'b1;
              ptr <= ptr_inc;
            end
            S_RD:  oe <= 1'b0;
            default: ;
          endcase
        end else if (bitc == 4'd9) begin
          bitc <= '0;
          oe   <= 1'b0;
          case (st)
            S_ADDR:
              if (rw) begin
                st <= S_RD;
                if (blk) begin
                  sh <= NCNT;
                  oe <= ~NCNT[7];
                end else begin
                  sh  <= rd_val;
                  oe  <= ~rd_val[7];
                  ptr <= ptr_inc;
                end
              end else begin
                st <= S_CMD;
              end
            S_CMD: st <= (blk && !skip) ? S_CNT : S_WR;
            S_CNT: st <= S_WR;
            S_RD: begin
              sh  <= rd_val;
              oe  <= ~rd_val[7];
              ptr <= ptr_inc;
            end
            default: ;
          endcase
        end else if (st == S_RD) begin
          oe <= ~sh[6];
          sh <= {sh[6:0], 1'b0};
        end
      end
    end
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk #(
  parameter int NREG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [8*NREG-1:0] regs_o
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  a_r1_reset_default: assert property (@(posedge clk) !rst_n |=> regs_o[7:0] == 8'hFF);

  a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r3_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  a_r4_store_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o[15:0]) |-> sda_oe);
endmodule

bind smb_regbank smb_regbank_chk #(.NREG(NREG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .regs_o (regs_o)
);

// File: tb/test_smb_regbank.sv
`timescale 1ns/1ps
module test_smb_regbank;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic [7:0]  idb = 8'h4A;
  logic        sda_oe;
  logic [47:0] regs;
  wire         sda_bus = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_v[$];
  string      exp_t[$];
  logic [7:0] act_v[$];

  smb_regbank i_smb_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .id_i(idb), .regs_o(regs)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send(logic [7:0] b, logic exp_ack, string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1;   wq(Q);
      scl = 1'b0;   wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_bus;
    scl = 1'b0;   wq(Q);
    chk(tag, ack, exp_ack);
  endtask

  task automatic recv(logic nack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_bus;
      scl = 1'b0;
    end
    wq(Q);
    sda_m = nack; wq(Q);
    scl = 1'b1;   wq(Q);
    scl = 1'b0;   wq(Q);
    sda_m = 1'b1;
    act_v.push_back(b);
  endtask

  task automatic expect_byte(logic [7:0] v, string tag);
    exp_v.push_back(v);
    exp_t.push_back(tag);
  endtask

  task automatic wr1(logic [6:0] off, logic [7:0] val);
    bstart();
    send(8'hD2, 1'b1, "R2 write address ack");
    send({1'b1, off}, 1'b1, "R4 command ack");
    send(val, 1'b1, "R3 data ack");
    bstop();
  endtask

  task automatic rd1(logic [6:0] off, logic [7:0] v, string tag);
    expect_byte(v, tag);
    bstart();
    send(8'hD2, 1'b1, "R2 write address ack");
    send({1'b1, off}, 1'b1, "R5 command ack");
    bstart();
    send(8'hD3, 1'b1, "R5 read address ack");
    recv(1'b1);
    wq(4);
    chk("R5 SDA released after NACK", sda_oe, 1'b0);
    bstop();
  endtask

  initial begin : monitor
    logic [7:0] a, e;
    string t;
    forever begin
      wait (act_v.size() > 0);
      a = act_v.pop_front();
      if (exp_v.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 unexpected byte actual=%h expected=none", a);
      end else begin
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        chk(t, a, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    wq(5);
    chk("R1 SDA idle in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    wq(5);
    chk("R1 R11 reset register image", regs, 48'h0000_4A05_FFFF);

    rd1(7'd0, 8'hFF, "R1 R5 byte read of enable register");
    rd1(7'd3, 8'h4A, "R9 ID register read");

    wr1(7'd4, 8'h5A);
    chk("R4 R11 byte write to offset 4", regs, 48'h005A_4A05_FFFF);
    rd1(7'd4, 8'h5A, "R5 read back offset 4");

    bstart();
    send(8'hA0, 1'b0, "R2 foreign address not acked");
    send(8'h84, 1'b0, "R2 command after foreign address ignored");
    send(8'h11, 1'b0, "R2 data after foreign address ignored");
    bstop();
    bstart();
    send(8'hD3 ^ 8'h02, 1'b0, "R2 foreign read address not acked");
    bstop();
    chk("R2 registers untouched by foreign address", regs, 48'h005A_4A05_FFFF);

    wr1(7'd2, 8'h7F);
    wr1(7'd3, 8'h00);
    chk("R9 read-only bits ignore writes", regs, 48'h005A_4A7D_FFFF);
    strap = 3'b010;
    wq(2);
    rd1(7'd2, 8'h7A, "R9 strap bits follow input");

    wr1(7'd10, 8'h33);
    chk("R10 write beyond last register ignored", regs, 48'h005A_4A7A_FFFF);
    rd1(7'd10, 8'h00, "R10 read beyond last register");

    bstart();
    send(8'hD2, 1'b1, "R6 block address ack");
    send(8'h00, 1'b1, "R6 block command ack");
    send(8'h03, 1'b1, "R6 count ack");
    send(8'h11, 1'b1, "R6 data ack");
    send(8'h22, 1'b1, "R6 data ack");
    send(8'h33, 1'b1, "R6 data ack");
    bstop();
    chk("R6 block write with count", regs, 48'h005A_4A32_2211);

    bstart();
    send(8'hD2, 1'b1, "R6 block address ack");
    send(8'h00, 1'b1, "R6 block command ack");
    send(8'h05, 1'b1, "R6 count ack");
    send(8'hA1, 1'b1, "R6 data ack");
    send(8'hA2, 1'b1, "R6 data ack");
    bstop();
    chk("R6 block write stopped early", regs, 48'h005A_4A32_A2A1);

    wr1(7'd2, 8'h80);
    chk("R7 count-skip bit set", regs, 48'h005A_4A82_A2A1);
    bstart();
    send(8'hD2, 1'b1, "R7 block address ack");
    send(8'h00, 1'b1, "R7 block command ack");
    send(8'hC1, 1'b1, "R7 first data ack");
    send(8'hC2, 1'b1, "R7 second data ack");
    bstop();
    chk("R7 block write without count", regs, 48'h005A_4A82_C2C1);
    wr1(7'd2, 8'h00);
    chk("R7 count-skip bit cleared", regs, 48'h005A_4A02_C2C1);

    expect_byte(8'h06, "R8 count byte");
    expect_byte(8'hC1, "R8 register 0");
    expect_byte(8'hC2, "R8 register 1");
    expect_byte(8'h02, "R8 register 2");
    expect_byte(8'h4A, "R8 register 3");
    expect_byte(8'h5A, "R8 register 4");
    expect_byte(8'h00, "R8 register 5");
    expect_byte(8'h00, "R10 block read past end");
    bstart();
    send(8'hD2, 1'b1, "R8 block address ack");
    send(8'h00, 1'b1, "R8 block command ack");
    bstart();
    send(8'hD3, 1'b1, "R8 read address ack");
    for (int i = 0; i < 7; i++) recv(1'b0);
    recv(1'b1);
    wq(4);
    chk("R8 SDA released after NACK", sda_oe, 1'b0);
    bstop();

    rd1(7'd1, 8'hC2, "R5 byte read after block read");

    wq(50);
    chk("R8 scoreboard drained", exp_v.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule